// File: doc/BRIEF.md
# Programmable Tick Interrupt Timer

The block produces a periodic interrupt from a 32768 Hz reference that arrives as a one-cycle enable strobe in the system clock domain. A power-of-two prescaler, set by a four-bit field, divides the strobe. A down-counter loaded from a reload register counts the divided pulses. Each time the counter runs out, a sticky status bit sets and the level interrupt output rises. The counter then reloads itself and keeps running until software stops it.

Software reaches the block through four word registers on a two-bit address. The registers are control, reload value, live count (read-only) and interrupt status (write-one-to-clear). The control word is stored as written. Three of its fields are decoded: bit 0 is the master enable, bit 8 is the tick enable and bits [7:4] are the rate select. Reads are combinational from the addressed register.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset, all four registers read 0, the counter is stopped and `tick_irq` is low.
- R2: A write to the reload register (address 1) is stored only when the written 32-bit value is greater than 2. Otherwise the register keeps its old value.
- R3: A control write (address 0) starts the counter only when bit 8 goes from 0 to 1 while the written bit 0 is 1 and the reload value is nonzero. A start loads the count with the reload value and clears the prescaler phase.
- R4: While running, the count drops by one on every divided pulse. A divided pulse is every 2^S-th reference strobe since the start, where S is the active rate select.
- R5: On a divided pulse that finds the count at 1, status bit 0 sets, `tick_irq` goes high and the count reloads from the reload register and keeps running. The interrupt period is therefore exactly the reload value in divided pulses.
- R6: A control write with bit 0 clear stops the counter. A control write with bit 0 set that clears bit 8 while bit 8 was set also stops it. A stopped count holds its value.
- R7: Writing a 1 to bit 0 of the status register (address 3) clears the status bit and lowers `tick_irq`. Writing 0 there has no effect. An expiry in the same cycle wins over the clear.
- R8: Control writes with bit 0 set load bits [7:4] as the new active rate select. The new rate takes effect without restarting the counter. After reset the rate is undivided (S = 0).
- R9: Address 2 reads the live count value, zero-extended. Writes to address 2 change nothing.
- R10: Address 0 reads back the last control word as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address: 0 control, 1 reload, 2 count, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| tick_irq | output | 1 | Level tick interrupt, equal to status bit 0 |

## Verification
Directed sequences apply reference strobes one by one at rate select 0 and 3, so that the exact strobe of each decrement and of the expiry can be told apart from an off-by-one. Further directed sequences check that a reload write of 1 or 2 is rejected and that a start is refused when only the tick enable is set. They also check that stops by either enable hold the count and that a write of 0 to status leaves the interrupt raised. A long seeded random phase then mixes strobes with writes to every address, including strobes that land in the same cycle as start, stop and clear writes, and compares every register and the interrupt against a bench model on each cycle.

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int CNT_W      = 16,
  parameter int MIN_RELOAD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_stb,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        tick_irq
);
  localparam int SEL_W = 4;
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] reload, cnt;
  logic [SEL_W-1:0] sel_act;
  logic [PRE_W-1:0] pre, mask;
  logic             run, stat;

  wire wr_ctrl   = wr_en && addr == 2'd0;
  wire wr_reload = wr_en && addr == 2'd1;
  wire wr_stat   = wr_en && addr == 2'd3;
  wire reload_ok = wdata > 32'(MIN_RELOAD);

  wire start = wr_ctrl && wdata[0] && wdata[8] && !ctrl_q[8] && reload != '0;
  wire stop  = wr_ctrl && (!wdata[0] || (ctrl_q[8] && !wdata[8]));

  assign mask = PRE_W'((32'd1 << sel_act) - 32'd1);
  wire div_pulse = run && ref_stb && ((pre & mask) == mask);
  wire expire    = div_pulse && cnt == CNT_W'(1) && !start && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      reload  <= '0;
      cnt     <= '0;
      sel_act <= '0;
      pre     <= '0;
      run     <= 1'b0;
      stat    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata;
        if (wdata[0]) sel_act <= wdata[7:4];
      end
      if (wr_reload && reload_ok) reload <= wdata[CNT_W-1:0];
      if (start) begin
        cnt <= reload;
        run <= 1'b1;
        pre <= '0;
      end else if (stop) begin
        run <= 1'b0;
      end else if (run && ref_stb) begin
        pre <= pre + PRE_W'(1);
        if (div_pulse) cnt <= (cnt == CNT_W'(1)) ? reload : cnt - CNT_W'(1);
      end
      if (expire) stat <= 1'b1;
      else if (wr_stat && wdata[0]) stat <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl_q;
      2'd1:    rdata = {{(32-CNT_W){1'b0}}, reload};
      2'd2:    rdata = {{(32-CNT_W){1'b0}}, cnt};
      default: rdata = {31'b0, stat};
    endcase
  end

  assign tick_irq = stat;

  assert_reload_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && !reload_ok) |=> $stable(reload));
  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && cnt == $past(reload)));
  assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt != '0);
  assert_expire_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tick_irq);
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !run);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[0] && !expire) |=> !tick_irq);
endmodule

// File: tb/rtc_tick_timer_bench.sv
module rtc_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_stb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  int unsigned m_ctrl, m_reload, m_cnt, m_sel, m_pre;
  bit m_run, m_stat;

  rtc_tick_timer u_rtc_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_irq(tick_irq)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl;
      2'd1:    return m_reload;
      2'd2:    return m_cnt;
      default: return {31'b0, m_stat};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0:    return "R10 control";
      2'd1:    return "R2 reload";
      2'd2:    return "R9 count";
      default: return "R7 status";
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_reload = 0; m_cnt = 0; m_sel = 0; m_pre = 0;
    m_run = 0; m_stat = 0;
  endtask

  task automatic model_step(input bit w, input logic [1:0] a, input logic [31:0] d, input bit r);
    int unsigned mask = (32'd1 << m_sel) - 1;
    bit pulse = m_run && r && ((m_pre & mask) == mask);
    bit wc = w && a == 2'd0;
    bit start = wc && d[0] && d[8] && !m_ctrl[8] && m_reload != 0;
    bit stop = wc && (!d[0] || (m_ctrl[8] && !d[8]));
    bit exp_hit = pulse && m_cnt == 1 && !start && !stop;
    if (start) begin
      m_cnt = m_reload; m_run = 1; m_pre = 0;
    end else if (stop) begin
      m_run = 0;
    end else if (m_run && r) begin
      m_pre = (m_pre + 1) & 32'h7fff;
      if (pulse) m_cnt = (m_cnt == 1) ? m_reload : m_cnt - 1;
    end
    if (exp_hit) m_stat = 1;
    else if (w && a == 2'd3 && d[0]) m_stat = 0;
    if (wc) begin
      m_ctrl = d;
      if (d[0]) m_sel = d[7:4];
    end
    if (w && a == 2'd1 && d > 2) m_reload = d[15:0];
  endtask

  task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d, input bit r);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ref_stb = r;
    #1;
    check(rdata == exp_rd(a), tag_of(a), rdata, exp_rd(a));
    check(tick_irq == m_stat, "R5 irq", {31'b0, tick_irq}, {31'b0, m_stat});
    @(posedge clk);
    model_step(w, a, d, r);
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input bit exp_irq, input string tag);
    @(negedge clk);
    wr_en = 0; addr = a; wdata = '0; ref_stb = 0;
    #1;
    check(rdata == exp, tag, rdata, exp);
    check(tick_irq == exp_irq, tag, {31'b0, tick_irq}, {31'b0, exp_irq});
    @(posedge clk);
    model_step(0, a, '0, 0);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd2, '0, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) peek(2'(a), 32'd0, 1'b0, "R1 reset");

    // R2 reload acceptance
    cyc(1, 2'd1, 32'd2, 0);
    peek(2'd1, 32'd0, 1'b0, "R2 reject 2");
    cyc(1, 2'd1, 32'd5, 0);
    peek(2'd1, 32'd5, 1'b0, "R2 accept 5");
    cyc(1, 2'd1, 32'd1, 0);
    peek(2'd1, 32'd5, 1'b0, "R2 reject 1");

    // R3 no start without master enable
    cyc(1, 2'd0, 32'h100, 0);
    strobes(3);
    peek(2'd2, 32'd0, 1'b0, "R3 no start");
    cyc(1, 2'd0, 32'h000, 0);
    cyc(1, 2'd0, 32'h101, 0);
    peek(2'd2, 32'd5, 1'b0, "R3 start load");
    peek(2'd0, 32'h101, 1'b0, "R10 readback");

    // R4 undivided rate after reset, R5 expiry
    strobes(1);
    peek(2'd2, 32'd4, 1'b0, "R4 first decrement");
    strobes(3);
    peek(2'd2, 32'd1, 1'b0, "R4 count to 1");
    strobes(1);
    peek(2'd2, 32'd5, 1'b1, "R5 expiry reload");

    // R7 status clear
    cyc(1, 2'd3, 32'd0, 0);
    peek(2'd3, 32'd1, 1'b1, "R7 write 0 keeps");
    cyc(1, 2'd3, 32'd1, 0);
    peek(2'd3, 32'd0, 1'b0, "R7 W1C");

    // R9 writes to count ignored
    cyc(1, 2'd2, 32'd77, 0);
    peek(2'd2, 32'd5, 1'b0, "R9 write ignored");

    // R6 stop by tick enable, hold
    strobes(2);
    cyc(1, 2'd0, 32'h001, 0);
    strobes(2);
    peek(2'd2, 32'd3, 1'b0, "R6 tick stop holds");
    cyc(1, 2'd0, 32'h101, 0);
    peek(2'd2, 32'd5, 1'b0, "R3 restart");

    // R8 rate change mid-run to divide by 8
    cyc(1, 2'd0, 32'h131, 0);
    strobes(7);
    peek(2'd2, 32'd5, 1'b0, "R8 seven strobes");
    strobes(1);
    peek(2'd2, 32'd4, 1'b0, "R8 eighth strobe");

    // R6 stop by master enable
    cyc(1, 2'd0, 32'h000, 0);
    strobes(16);
    peek(2'd2, 32'd4, 1'b0, "R6 master stop holds");

    // random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      int unsigned k = $urandom % 100;
      if (k < 70) begin
        cyc(0, 2'($urandom % 4), '0, 1);
      end else begin
        logic [1:0] a = 2'($urandom % 4);
        logic [31:0] d;
        case (a)
          2'd0: d = {23'b0, 1'($urandom % 2), 4'($urandom % 3), 3'b0, 1'(($urandom % 4) != 0)};
          2'd1: d = $urandom % 9;
          2'd2: d = $urandom;
          default: d = $urandom % 2;
        endcase
        cyc(1, a, d, 1'($urandom % 2));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule